// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is the storage and output-select stage of a programmable logic cell. Static configuration inputs pick where the stored bit gets its data, which clock it follows, whether a clock-enable term gates that clock, and which signals clear or preset it asynchronously. The element can act as a D, T, JK or SR flip-flop, or as a level-sensitive latch. The pin output and the internal feedback output each choose, independently, between the stored value and the combinational XOR result.

The element is a vector of `WIDTH` identical bit cells. All bits share one configuration, one clock and one set of asynchronous controls. Each bit has its own data inputs. A chip-level active-low reset clears every bit at once. The release of that reset is retimed onto the global clock through `SYNC_STAGES` flops. Flip-flop modes and latch mode each keep their own state, so changing the mode brings back whatever the other storage last held.

Top module: `mcell_storage`

## Requirements
- R1: While `rst_n` is low, every stored bit is 0. After `rst_n` rises, the clear stays in force through the first `SYNC_STAGES` (default 2) rising edges of `gclk`. The first edge that can load data is edge `SYNC_STAGES+1`.
- R2: `cfg_dsrc` selects the data source: 0 or 3 selects `xor_res`, 1 selects `data_term`, 2 selects `pin_in`.
- R3: With `cfg_mode` 0 (D), the state takes the selected data on each active clock rising edge.
- R4: With `cfg_mode` 1 (T), a bit toggles on an active rising edge when its data bit is 1 and holds when its data bit is 0.
- R5: With `cfg_mode` 2 (JK), the data bit is J and `aux_term` is K. On an active rising edge, J=0 K=0 holds, J=1 K=0 sets, J=0 K=1 clears and J=1 K=1 toggles.
- R6: With `cfg_mode` 3 (SR), the data bit is S and `aux_term` is R. On an active rising edge, S=1 R=0 sets, S=0 R=1 clears, and S=R=0 or S=R=1 holds.
- R7: With `cfg_mode` 4 (latch), the latch state follows the selected data while the selected clock is high and holds while it is low. The clock enable does not act in this mode.
- R8: `cfg_csrc` 0 clocks the element from `gclk`. `cfg_csrc` 1 clocks it from `clk_term`, and `gclk` edges then have no effect.
- R9: When `cfg_csrc` is 0 and `cfg_ce_en` is 1, a low `ce_term` makes `gclk` edges have no effect on flip-flop state. When `cfg_csrc` is 1, `ce_term` and `cfg_ce_en` have no effect.
- R10: `cfg_clr` selects the asynchronous clear: 0 none, 1 `gclr`, 2 `clr_term`, 3 `gclr` OR `clr_term`. An active clear forces the state to 0 at once, without a clock.
- R11: `cfg_pre` 1 lets `pre_term` force the state to 1 at once. `cfg_pre` 0 ignores `pre_term`. When clear and preset are both active, the state is 0.
- R12: `cfg_out_reg` 1 drives `pin_out` from the state, and 0 drives it from `xor_res`. `cfg_fb_reg` makes the same choice for `fb_out`, independently.
- R13: `cfg_mode` values 5, 6 and 7 behave as D mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Chip reset, active low, asserted asynchronously |
| gclk | input | 1 | Global clock |
| gclr | input | 1 | Global asynchronous clear, active high |
| clk_term | input | 1 | Product-term clock |
| ce_term | input | 1 | Clock-enable term, active high |
| clr_term | input | 1 | Clear term, active high |
| pre_term | input | 1 | Preset term, active high |
| xor_res | input | WIDTH | XOR gate result, which is also the combinational value |
| data_term | input | WIDTH | Dedicated data term |
| pin_in | input | WIDTH | Value read back from the pin |
| aux_term | input | WIDTH | K input in JK mode, R input in SR mode |
| cfg_mode | input | 3 | Storage mode: 0 D, 1 T, 2 JK, 3 SR, 4 latch |
| cfg_dsrc | input | 2 | Data source select |
| cfg_csrc | input | 1 | Clock source: 0 global, 1 term |
| cfg_ce_en | input | 1 | Enables the clock-enable term |
| cfg_clr | input | 2 | Clear source select |
| cfg_pre | input | 1 | Enables the preset term |
| cfg_out_reg | input | 1 | Pin output: 1 stored, 0 combinational |
| cfg_fb_reg | input | 1 | Feedback output: 1 stored, 0 combinational |
| pin_out | output | WIDTH | Value toward the pin driver |
| fb_out | output | WIDTH | Value toward the feedback bus |

## Verification
On every global clock edge, the assertions check that an active clear holds the state at zero and that a lone preset holds it at one. They also check that a gated global clock leaves the flip-flop unchanged, that T mode flips exactly the bits whose data is set, and that the two outputs agree whenever they make the same selection. The bench scenarios are what show that JK and SR decode correctly and that a latch follows its data only while its clock is high. They also show that the product-term clock takes over from the global clock, that each clear source acts (or is ignored) at once without a clock, and that reset release is counted correctly. A model in the bench follows both stored states through random configuration changes.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  typedef enum logic [2:0] {
    MODE_D     = 3'd0,
    MODE_T     = 3'd1,
    MODE_JK    = 3'd2,
    MODE_SR    = 3'd3,
    MODE_LATCH = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    DSRC_XOR  = 2'd0,
    DSRC_TERM = 2'd1,
    DSRC_PIN  = 2'd2,
    DSRC_XOR2 = 2'd3
  } dsrc_e;

  typedef enum logic [1:0] {
    CLR_NONE   = 2'd0,
    CLR_GLOBAL = 2'd1,
    CLR_TERM   = 2'd2,
    CLR_EITHER = 2'd3
  } clr_sel_e;

  // Codes above the latch code fall back to D operation.
  function automatic mode_e decode_mode(input logic [2:0] raw);
    mode_e m;
    case (raw)
      3'd1:    m = MODE_T;
      3'd2:    m = MODE_JK;
      3'd3:    m = MODE_SR;
      3'd4:    m = MODE_LATCH;
      default: m = MODE_D;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/mcell_rst_sync.sv
module mcell_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_rel
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_rel = shift_q[STAGES-1];

  // R1
  sync_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_rel) |-> $past(rst_n));

endmodule

// File: rtl/mcell_src_sel.sv
module mcell_src_sel
  import mcell_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             rst_rel,
  input  logic             gclk,
  input  logic             gclr,
  input  logic             clk_term,
  input  logic             ce_term,
  input  logic             clr_term,
  input  logic             pre_term,
  input  logic [WIDTH-1:0] xor_res,
  input  logic [WIDTH-1:0] data_term,
  input  logic [WIDTH-1:0] pin_in,
  input  dsrc_e            dsrc,
  input  logic             csrc_term,
  input  logic             ce_en,
  input  clr_sel_e         clr_sel,
  input  logic             pre_en,
  output logic [WIDTH-1:0] d_sel,
  output logic             eff_clk,
  output logic             ce_ok,
  output logic             clr_act,
  output logic             pre_act
);

  logic clr_cfg;

  always_comb begin
    case (dsrc)
      DSRC_TERM: d_sel = data_term;
      DSRC_PIN:  d_sel = pin_in;
      default:   d_sel = xor_res;
    endcase
  end

  always_comb begin
    case (clr_sel)
      CLR_GLOBAL: clr_cfg = gclr;
      CLR_TERM:   clr_cfg = clr_term;
      CLR_EITHER: clr_cfg = gclr | clr_term;
      default:    clr_cfg = 1'b0;
    endcase
  end

  // The clock enable is only meaningful with the global clock.
  assign eff_clk = csrc_term ? clk_term : gclk;
  assign ce_ok   = csrc_term | ~ce_en | ce_term;
  assign clr_act = clr_cfg | ~rst_rel;
  assign pre_act = pre_en & pre_term;

endmodule

// File: rtl/mcell_next.sv
module mcell_next
  import mcell_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  mode_e            mode,
  input  logic             ce_ok,
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] d,
  input  logic [WIDTH-1:0] aux,
  output logic [WIDTH-1:0] nxt
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic nb;
    always_comb begin
      nb = q[b];
      if (ce_ok) begin
        case (mode)
          MODE_D:  nb = d[b];
          MODE_T:  nb = d[b] ? ~q[b] : q[b];
          MODE_JK: begin
            case ({d[b], aux[b]})
              2'b01:   nb = 1'b0;
              2'b10:   nb = 1'b1;
              2'b11:   nb = ~q[b];
              default: nb = q[b];
            endcase
          end
          MODE_SR: begin
            case ({d[b], aux[b]})
              2'b01:   nb = 1'b0;
              2'b10:   nb = 1'b1;
              default: nb = q[b];
            endcase
          end
          default: nb = q[b];
        endcase
      end
    end
    assign nxt[b] = nb;
  end

endmodule

// File: rtl/mcell_regbank.sv
module mcell_regbank
  import mcell_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             gclk,
  input  logic             rst_n,
  input  logic             eff_clk,
  input  logic             clr_act,
  input  logic             pre_act,
  input  logic             ce_ok,
  input  logic             csrc_term,
  input  mode_e            mode,
  input  logic [WIDTH-1:0] d,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] ff_q,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] lat_q;
  logic             lat_mode;
  logic             lat_en;

  assign lat_mode = (mode == MODE_LATCH);
  assign lat_en   = lat_mode & eff_clk;

  always_ff @(posedge eff_clk or posedge clr_act or posedge pre_act) begin
    if (clr_act) begin
      ff_q <= '0;
    end else if (pre_act) begin
      ff_q <= '1;
    end else begin
      ff_q <= nxt;
    end
  end

  always_latch begin
    if (clr_act) begin
      lat_q = '0;
    end else if (pre_act) begin
      lat_q = '1;
    end else if (lat_en) begin
      lat_q = d;
    end
  end

  assign q = lat_mode ? lat_q : ff_q;

  // R10
  clear_forces_zero_chk: assert property (@(posedge gclk) disable iff (!rst_n)
    clr_act |-> (q == '0));

  // R11
  preset_forces_one_chk: assert property (@(posedge gclk) disable iff (!rst_n)
    (pre_act && !clr_act) |-> (q == '1));

  // R9
  ce_gate_hold_chk: assert property (@(posedge gclk) disable iff (!rst_n)
    (!ce_ok && !clr_act && !pre_act) |=>
      (clr_act || pre_act || csrc_term || $stable(ff_q)));

  // R4
  t_flip_chk: assert property (@(posedge gclk) disable iff (!rst_n)
    (mode == MODE_T && !csrc_term && ce_ok && !clr_act && !pre_act) |=>
      (clr_act || pre_act || csrc_term || ((ff_q ^ $past(ff_q)) == $past(d))));

endmodule

// File: rtl/mcell_storage.sv
module mcell_storage
  import mcell_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             rst_n,
  input  logic             gclk,
  input  logic             gclr,
  input  logic             clk_term,
  input  logic             ce_term,
  input  logic             clr_term,
  input  logic             pre_term,
  input  logic [WIDTH-1:0] xor_res,
  input  logic [WIDTH-1:0] data_term,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] aux_term,
  input  logic [2:0]       cfg_mode,
  input  logic [1:0]       cfg_dsrc,
  input  logic             cfg_csrc,
  input  logic             cfg_ce_en,
  input  logic [1:0]       cfg_clr,
  input  logic             cfg_pre,
  input  logic             cfg_out_reg,
  input  logic             cfg_fb_reg,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] fb_out
);

  logic             rst_rel;
  logic [WIDTH-1:0] d_sel;
  logic             eff_clk;
  logic             ce_ok;
  logic             clr_act;
  logic             pre_act;
  logic [WIDTH-1:0] ff_q;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] st_q;
  mode_e            mode;

  assign mode = decode_mode(cfg_mode);

  mcell_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (gclk),
    .rst_n   (rst_n),
    .rst_rel (rst_rel)
  );

  mcell_src_sel #(.WIDTH(WIDTH)) u_sel (
    .rst_rel   (rst_rel),
    .gclk      (gclk),
    .gclr      (gclr),
    .clk_term  (clk_term),
    .ce_term   (ce_term),
    .clr_term  (clr_term),
    .pre_term  (pre_term),
    .xor_res   (xor_res),
    .data_term (data_term),
    .pin_in    (pin_in),
    .dsrc      (dsrc_e'(cfg_dsrc)),
    .csrc_term (cfg_csrc),
    .ce_en     (cfg_ce_en),
    .clr_sel   (clr_sel_e'(cfg_clr)),
    .pre_en    (cfg_pre),
    .d_sel     (d_sel),
    .eff_clk   (eff_clk),
    .ce_ok     (ce_ok),
    .clr_act   (clr_act),
    .pre_act   (pre_act)
  );

  mcell_next #(.WIDTH(WIDTH)) u_next (
    .mode  (mode),
    .ce_ok (ce_ok),
    .q     (ff_q),
    .d     (d_sel),
    .aux   (aux_term),
    .nxt   (nxt)
  );

  mcell_regbank #(.WIDTH(WIDTH)) u_bank (
    .gclk      (gclk),
    .rst_n     (rst_n),
    .eff_clk   (eff_clk),
    .clr_act   (clr_act),
    .pre_act   (pre_act),
    .ce_ok     (ce_ok),
    .csrc_term (cfg_csrc),
    .mode      (mode),
    .d         (d_sel),
    .nxt       (nxt),
    .ff_q      (ff_q),
    .q         (st_q)
  );

  assign pin_out = cfg_out_reg ? st_q : xor_res;
  assign fb_out  = cfg_fb_reg  ? st_q : xor_res;

  // R12
  out_fb_agree_chk: assert property (@(posedge gclk) disable iff (!rst_n)
    (cfg_out_reg == cfg_fb_reg) |-> (pin_out == fb_out));

endmodule

// File: tb/mcell_storage_tb.sv
`timescale 1ns/1ps
module mcell_storage_tb_top;

  localparam int W    = 4;
  localparam int SYNC = 2;

  logic         rst_n, gclk, gclr, clk_term, ce_term, clr_term, pre_term;
  logic [W-1:0] xor_res, data_term, pin_in, aux_term;
  logic [2:0]   cfg_mode;
  logic [1:0]   cfg_dsrc, cfg_clr;
  logic         cfg_csrc, cfg_ce_en, cfg_pre, cfg_out_reg, cfg_fb_reg;
  logic [W-1:0] pin_out, fb_out;

  logic [W-1:0] m_ff, m_lat;
  int           rs_cnt;
  int           n_chk, n_bad;
  bit           done;

  mcell_storage #(.WIDTH(W), .SYNC_STAGES(SYNC)) dut_i (
    .rst_n(rst_n), .gclk(gclk), .gclr(gclr), .clk_term(clk_term),
    .ce_term(ce_term), .clr_term(clr_term), .pre_term(pre_term),
    .xor_res(xor_res), .data_term(data_term), .pin_in(pin_in),
    .aux_term(aux_term), .cfg_mode(cfg_mode), .cfg_dsrc(cfg_dsrc),
    .cfg_csrc(cfg_csrc), .cfg_ce_en(cfg_ce_en), .cfg_clr(cfg_clr),
    .cfg_pre(cfg_pre), .cfg_out_reg(cfg_out_reg), .cfg_fb_reg(cfg_fb_reg),
    .pin_out(pin_out), .fb_out(fb_out)
  );

  initial gclk = 1'b0;
  always #5 gclk = ~gclk;

  function automatic logic [W-1:0] b_d();
    if (cfg_dsrc == 2'd1) return data_term;
    if (cfg_dsrc == 2'd2) return pin_in;
    return xor_res;
  endfunction

  function automatic bit b_latch();
    return cfg_mode == 3'd4;
  endfunction

  function automatic bit b_clr();
    bit c;
    c = !rst_n || (rs_cnt < SYNC);
    if (cfg_clr == 2'd1) c = c || gclr;
    if (cfg_clr == 2'd2) c = c || clr_term;
    if (cfg_clr == 2'd3) c = c || gclr || clr_term;
    return c;
  endfunction

  function automatic bit b_pre();
    return cfg_pre && pre_term;
  endfunction

  function automatic bit b_ce_ok();
    return !(!cfg_csrc && cfg_ce_en && !ce_term);
  endfunction

  function automatic logic [W-1:0] b_next(input logic [W-1:0] q);
    logic [W-1:0] d;
    d = b_d();
    case (cfg_mode)
      3'd1: return q ^ d;
      3'd2: return (d & ~q) | (~aux_term & q);
      3'd3: return (d & ~aux_term) | (q & ~(d ^ aux_term));
      default: return d;
    endcase
  endfunction

  function automatic string mode_tag();
    case (cfg_mode)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input string tag);
    logic [W-1:0] q, ep, ef;
    q  = b_latch() ? m_lat : m_ff;
    ep = cfg_out_reg ? q : xor_res;
    ef = cfg_fb_reg ? q : xor_res;
    n_chk++;
    if (pin_out !== ep || fb_out !== ef) begin
      n_bad++;
      $display("FAIL %s pin_out=%h expected %h fb_out=%h expected %h at %0t",
               tag, pin_out, ep, fb_out, ef, $time);
    end
  endtask

  // Apply asynchronous and level-sensitive effects, then check.
  task automatic settle(input string tag);
    if (b_clr()) begin
      m_ff = '0; m_lat = '0;
    end else if (b_pre()) begin
      m_ff = '1; m_lat = '1;
    end else if (b_latch() && (cfg_csrc ? clk_term : gclk)) begin
      m_lat = b_d();
    end
    #1;
    check(tag);
  endtask

  // One global clock period: edge, check in high phase, return at low+1.
  task automatic cyc(input string tag);
    @(posedge gclk);
    if (!b_latch() && !cfg_csrc && b_ce_ok() && !b_clr() && !b_pre())
      m_ff = b_next(m_ff);
    if (rst_n && rs_cnt < SYNC) rs_cnt++;
    #1;
    settle(tag);
    @(negedge gclk);
    #1;
  endtask

  task automatic term_pulse(input string tag);
    clk_term = 1'b1;
    if (!b_latch() && cfg_csrc && !b_clr() && !b_pre())
      m_ff = b_next(m_ff);
    settle(tag);
    clk_term = 1'b0;
    settle(tag);
  endtask

  task automatic pulse_clr(input logic g, input logic t, input string tag);
    gclr = g; clr_term = t;
    settle(tag);
    cyc(tag);
    gclr = 1'b0; clr_term = 1'b0;
    settle(tag);
  endtask

  task automatic pulse_pre(input string tag);
    pre_term = 1'b1;
    settle(tag);
    cyc(tag);
    pre_term = 1'b0;
    settle(tag);
  endtask

  task automatic reload(input logic [W-1:0] v, input string tag);
    data_term = v; ce_term = 1'b1;
    cyc(tag);
    ce_term = 1'b0;
    settle(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    n_chk = 0; n_bad = 0; done = 0; rs_cnt = 0;
    m_ff = '0; m_lat = '0;
    rst_n = 1'b0; gclr = 1'b0; clk_term = 1'b0; ce_term = 1'b0;
    clr_term = 1'b0; pre_term = 1'b0;
    xor_res = 4'hF; data_term = 4'hF; pin_in = 4'h0; aux_term = 4'h0;
    cfg_mode = 3'd0; cfg_dsrc = 2'd0; cfg_csrc = 1'b0; cfg_ce_en = 1'b0;
    cfg_clr = 2'd0; cfg_pre = 1'b0; cfg_out_reg = 1'b1; cfg_fb_reg = 1'b1;
    #1;
    settle("R1");
    cyc("R1");
    cyc("R1");
    rst_n = 1'b1;
    settle("R1");
    cyc("R1");
    cyc("R1");
    cyc("R1");

    // R2 data source selection
    xor_res = 4'hA; data_term = 4'h5; pin_in = 4'hC;
    for (int s = 0; s < 4; s++) begin
      cfg_dsrc = 2'(s);
      settle("R2");
      cyc("R2");
    end

    // R3 D mode
    cfg_dsrc = 2'd1;
    data_term = 4'h3; cyc("R3");
    data_term = 4'h6; cyc("R3");

    // R4 T mode
    cfg_mode = 3'd1; data_term = 4'b0101;
    cyc("R4"); cyc("R4");
    data_term = 4'h0; cyc("R4");

    // R5 JK mode: bits cover all four J/K pairs
    cfg_mode = 3'd2; data_term = 4'b1100; aux_term = 4'b1010;
    cyc("R5"); cyc("R5"); cyc("R5");

    // R6 SR mode
    cfg_mode = 3'd3;
    cyc("R6"); cyc("R6");
    data_term = 4'hF; aux_term = 4'hF; cyc("R6");
    data_term = 4'h0; aux_term = 4'h0; cyc("R6");

    // R13 undefined codes act as D
    cfg_mode = 3'd5; data_term = 4'h9; cyc("R13");
    cfg_mode = 3'd7; data_term = 4'h6; cyc("R13");

    // R7 latch on the global clock
    cfg_mode = 3'd4; data_term = 4'hA; settle("R7");
    cyc("R7");
    data_term = 4'h5; settle("R7");
    cyc("R7");
    // R7 latch on the term clock
    cfg_csrc = 1'b1; data_term = 4'h3; settle("R7");
    cyc("R7");
    clk_term = 1'b1; settle("R7");
    data_term = 4'hC; settle("R7");
    clk_term = 1'b0; settle("R7");
    cyc("R7");
    data_term = 4'h0; settle("R7");
    cyc("R7");

    // R8 term clock for flip-flops
    cfg_mode = 3'd0; data_term = 4'h7; settle("R8");
    cyc("R8");
    term_pulse("R8");
    cyc("R8");

    // R9 clock enable
    cfg_csrc = 1'b0; cfg_ce_en = 1'b1; ce_term = 1'b0; data_term = 4'h2;
    cyc("R9"); cyc("R9");
    ce_term = 1'b1; cyc("R9");
    ce_term = 1'b0; cfg_csrc = 1'b1; data_term = 4'hB;
    term_pulse("R9");
    cyc("R9");
    cfg_ce_en = 1'b0; cfg_csrc = 1'b0; data_term = 4'h4;
    cyc("R9");

    // R10 clear sources, state frozen by the clock enable
    cfg_ce_en = 1'b1; ce_term = 1'b0;
    reload(4'hF, "R10");
    cfg_clr = 2'd0; pulse_clr(1'b1, 1'b1, "R10");
    cfg_clr = 2'd1; pulse_clr(1'b0, 1'b1, "R10");
    pulse_clr(1'b1, 1'b0, "R10");
    reload(4'hF, "R10");
    cfg_clr = 2'd2; pulse_clr(1'b1, 1'b0, "R10");
    pulse_clr(1'b0, 1'b1, "R10");
    reload(4'hF, "R10");
    cfg_clr = 2'd3; pulse_clr(1'b1, 1'b0, "R10");
    reload(4'hF, "R10");
    pulse_clr(1'b0, 1'b1, "R10");

    // R11 preset and clear priority
    cfg_pre = 1'b0; pulse_pre("R11");
    cfg_pre = 1'b1; pulse_pre("R11");
    cfg_clr = 2'd1;
    gclr = 1'b1; pre_term = 1'b1; settle("R11");
    cyc("R11");
    pre_term = 1'b0; settle("R11");
    gclr = 1'b0; settle("R11");
    cyc("R11");

    // R12 independent output selection
    reload(4'hF, "R12");
    xor_res = 4'h5;
    for (int k = 0; k < 4; k++) begin
      cfg_out_reg = k[0]; cfg_fb_reg = k[1];
      settle("R12");
      cyc("R12");
    end

    // Random phase
    cfg_ce_en = 1'b0; cfg_clr = 2'd0; cfg_pre = 1'b0;
    seed_v = $urandom(32'd20250101);
    for (int it = 0; it < 500; it++) begin
      int act;
      cfg_mode    = 3'($urandom_range(0, 7));
      cfg_dsrc    = 2'($urandom_range(0, 3));
      cfg_csrc    = 1'($urandom_range(0, 1));
      cfg_ce_en   = 1'($urandom_range(0, 1));
      cfg_clr     = 2'($urandom_range(0, 3));
      cfg_pre     = 1'($urandom_range(0, 1));
      cfg_out_reg = 1'($urandom_range(0, 1));
      cfg_fb_reg  = 1'($urandom_range(0, 1));
      ce_term     = 1'($urandom_range(0, 1));
      xor_res     = 4'($urandom_range(0, 15));
      data_term   = 4'($urandom_range(0, 15));
      pin_in      = 4'($urandom_range(0, 15));
      aux_term    = 4'($urandom_range(0, 15));
      settle(mode_tag());
      act = int'($urandom_range(0, 4));
      if (act == 2) begin
        term_pulse("R8");
      end else if (act == 3) begin
        pulse_clr(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R10");
      end else if (act == 4) begin
        pulse_pre("R11");
      end
      cyc(mode_tag());
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule